// File: doc/BRIEF.md
# Power-Up Strap Sampling Sequencer

This block shares five pins between two jobs. Right after power-on reset each pin is a configuration input: its output driver stays off and an external pull resistor sets its level. Once a settling window of fixed length has elapsed, the sequencer takes one snapshot of the synchronised pin levels into holding latches. One cycle later it turns all five output drivers on, and from then on each pin carries its clock.

Four of the captured bits form a frequency-select code. The fifth picks the function of a shared stop/reference pin. The snapshot is sticky: it changes only when the power-on reset is asserted again, which stands in for a full power cycle. The window length, given in reference-clock cycles, and the synchroniser depth are both parameters.

Top module: `strap_boot_seq`

## Requirements
- R1: While `por_n` is low, `pin_oe`, `pin_out`, `freq_sel`, `mode_sel` and `strap_valid` are all 0, whatever `pin_in` and `clk_src` do.
- R2: Count rising edges of `clk` from the first edge with `por_n` high as edge 1. Through edge WINDOW_CYCLES, `pin_oe` stays 0 and `strap_valid` stays 0.
- R3: Capture happens on edge WINDOW_CYCLES+1 alone, and `strap_valid` rises on that edge. The value captured for each pin is its level at edge WINDOW_CYCLES+1-SYNC_STAGES. A low strap gives 0 and a high strap gives 1.
- R4: `pin_oe` becomes all ones on edge WINDOW_CYCLES+2, one edge after `strap_valid` rises, and then stays all ones. It is never nonzero while `strap_valid` is 0.
- R5: After capture, `freq_sel` and `mode_sel` ignore every change on `pin_in` until the next power-on reset.
- R6: Field mapping: pin bits 0 to 3 drive `freq_sel` bits 0 to 3, and pin bit 4 drives `mode_sel`.
- R7: Each `pin_out` bit equals the matching `clk_src` bit while `pin_oe` is set, and is 0 otherwise.
- R8: Asserting `por_n` again clears the snapshot. The next release starts a full new window and captures afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| por_n | input | 1 | Active-low power-on reset, asynchronous assert |
| pin_in | input | 5 | Levels read back from the five shared pins |
| clk_src | input | 5 | Clocks to be driven onto the pins once enabled |
| pin_oe | output | 5 | Output-driver enables; 0 means high impedance |
| pin_out | output | 5 | Gated data toward the pin drivers |
| freq_sel | output | 4 | Captured frequency-select code |
| mode_sel | output | 1 | Captured function select of the shared pin |
| strap_valid | output | 1 | High once the snapshot has been taken |

## Verification
Two events can meet on the same edge: a strap level still settling on a pin, and the snapshot itself. The synchroniser sets which pin edge the snapshot actually reflects. The bench provokes this in two runs. One moves the straps just before edge WINDOW_CYCLES+1-SYNC_STAGES, and the new value is expected. The other moves them just after that edge, and the old value is expected. A second overlap is a pin change at the moment the drivers turn on. That case is judged by requiring the captured code to stay frozen while `pin_out` starts following `clk_src`.

// File: rtl/strap_pkg.sv
package strap_pkg;

    // Sequencing phases after reset release.
    typedef enum logic [1:0] {
        PH_SETTLE = 2'd0,  // drivers off, straps settling
        PH_CAPT   = 2'd1,  // snapshot taken on the next edge
        PH_ARM    = 2'd2,  // snapshot held, drivers still off
        PH_DRIVE  = 2'd3   // drivers on
    } phase_e;

    // Bit positions of the captured word.
    localparam int FS_LSB   = 0;
    localparam int FS_W     = 4;
    localparam int MODE_BIT = 4;

endpackage

// File: rtl/strap_sync.sv
module strap_sync #(
    parameter int NUM_PINS    = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic [NUM_PINS-1:0] pin_async,
    output logic [NUM_PINS-1:0] pin_sync
);
    logic [SYNC_STAGES-1:0][NUM_PINS-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = pin_async;
        for (int s = 1; s < SYNC_STAGES; s++) begin
            chain_d[s] = chain_q[s-1];
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) chain_q <= '0;
        else        chain_q <= chain_d;
    end

    assign pin_sync = chain_q[SYNC_STAGES-1];
endmodule

// File: rtl/strap_phase_ctrl.sv
module strap_phase_ctrl
    import strap_pkg::*;
#(
    parameter int WINDOW_CYCLES = 28636
) (
    input  logic clk,
    input  logic por_n,
    output logic capture_en,
    output logic drive_en
);
    localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WINDOW_CYCLES - 1);

    typedef struct packed {
        phase_e           phase;
        logic [CNT_W-1:0] cnt;
    } ctrl_t;

    ctrl_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        unique case (st_q.phase)
            PH_SETTLE: begin
                if (st_q.cnt == LAST) st_d.phase = PH_CAPT;
                else                  st_d.cnt   = st_q.cnt + 1'b1;
            end
            PH_CAPT:  st_d.phase = PH_ARM;
            PH_ARM:   st_d.phase = PH_DRIVE;
            PH_DRIVE: st_d.phase = PH_DRIVE;
            default:  st_d.phase = PH_SETTLE;
        endcase
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) st_q <= '{phase: PH_SETTLE, cnt: '0};
        else        st_q <= st_d;
    end

    assign capture_en = (st_q.phase == PH_CAPT);
    assign drive_en   = (st_q.phase == PH_DRIVE);

    AST_CAPT_FROM_SETTLE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(capture_en) |-> $past(st_q.cnt) == LAST); // R3
    AST_CAPT_SINGLE: assert property (@(posedge clk) disable iff (!por_n)
        capture_en |=> !capture_en && !drive_en); // R3
    AST_DRIVE_STAYS: assert property (@(posedge clk) disable iff (!por_n)
        drive_en |=> drive_en); // R4
    AST_WINDOW_QUIET: assert property (@(posedge clk) disable iff (!por_n)
        (st_q.phase == PH_SETTLE) |=> !drive_en); // R2
endmodule

// File: rtl/strap_capture.sv
module strap_capture #(
    parameter int NUM_PINS = 5
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic                capture_en,
    input  logic [NUM_PINS-1:0] pin_sync,
    output logic [NUM_PINS-1:0] strap_bits,
    output logic                strap_valid
);
    typedef struct packed {
        logic                valid;
        logic [NUM_PINS-1:0] bits;
    } hold_t;

    hold_t hd_d, hd_q;

    always_comb begin
        hd_d = hd_q;
        if (capture_en && !hd_q.valid) begin
            hd_d.bits  = pin_sync;
            hd_d.valid = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) hd_q <= '0;
        else        hd_q <= hd_d;
    end

    assign strap_bits  = hd_q.bits;
    assign strap_valid = hd_q.valid;

    AST_STRAP_STICKY: assert property (@(posedge clk) disable iff (!por_n)
        hd_q.valid |=> $stable(hd_q.bits)); // R5
    AST_VALID_HOLDS: assert property (@(posedge clk) disable iff (!por_n)
        hd_q.valid |=> hd_q.valid); // R5
    AST_VALID_ON_CAPTURE: assert property (@(posedge clk) disable iff (!por_n)
        $rose(hd_q.valid) |-> $past(capture_en)); // R3
endmodule

// File: rtl/strap_boot_seq.sv
module strap_boot_seq
    import strap_pkg::*;
#(
    parameter int NUM_PINS      = 5,
    parameter int WINDOW_CYCLES = 28636,
    parameter int SYNC_STAGES   = 2
) (
    input  logic                clk,
    input  logic                por_n,
    input  logic [NUM_PINS-1:0] pin_in,
    input  logic [NUM_PINS-1:0] clk_src,
    output logic [NUM_PINS-1:0] pin_oe,
    output logic [NUM_PINS-1:0] pin_out,
    output logic [FS_W-1:0]     freq_sel,
    output logic                mode_sel,
    output logic                strap_valid
);
    logic [NUM_PINS-1:0] pin_sync;
    logic [NUM_PINS-1:0] strap_bits;
    logic                capture_en;
    logic                drive_en;

    strap_sync #(.NUM_PINS(NUM_PINS), .SYNC_STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .por_n     (por_n),
        .pin_async (pin_in),
        .pin_sync  (pin_sync)
    );

    strap_phase_ctrl #(.WINDOW_CYCLES(WINDOW_CYCLES)) u_phase (
        .clk        (clk),
        .por_n      (por_n),
        .capture_en (capture_en),
        .drive_en   (drive_en)
    );

    strap_capture #(.NUM_PINS(NUM_PINS)) u_capture (
        .clk         (clk),
        .por_n       (por_n),
        .capture_en  (capture_en),
        .pin_sync    (pin_sync),
        .strap_bits  (strap_bits),
        .strap_valid (strap_valid)
    );

    assign pin_oe   = {NUM_PINS{drive_en}};
    assign pin_out  = clk_src & pin_oe;
    assign freq_sel = strap_bits[FS_LSB +: FS_W];
    assign mode_sel = strap_bits[MODE_BIT];

    AST_OE_NEEDS_VALID: assert property (@(posedge clk) disable iff (!por_n)
        (|pin_oe) |-> strap_valid); // R4
    AST_OE_AFTER_VALID: assert property (@(posedge clk) disable iff (!por_n)
        $rose(pin_oe[0]) |-> $past(strap_valid)); // R4
    AST_CODE_FROZEN: assert property (@(posedge clk) disable iff (!por_n)
        strap_valid |=> $stable(freq_sel) && $stable(mode_sel)); // R5
endmodule

// File: tb/strap_boot_seq_tb.sv
module strap_boot_seq_tb_top;
    localparam int WIN  = 20;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic [4:0] pin_in = '0;
    logic [4:0] clk_src = '0;
    logic [4:0] pin_oe, pin_out;
    logic [3:0] freq_sel;
    logic       mode_sel, strap_valid;

    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;

    strap_boot_seq #(.NUM_PINS(5), .WINDOW_CYCLES(WIN), .SYNC_STAGES(SYNC)) dut_i (
        .clk(clk), .por_n(por_n), .pin_in(pin_in), .clk_src(clk_src),
        .pin_oe(pin_oe), .pin_out(pin_out), .freq_sel(freq_sel),
        .mode_sel(mode_sel), .strap_valid(strap_valid)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    // Release reset at a falling edge; the next rising edge is edge 1.
    task automatic power_up(input logic [4:0] straps);
        por_n = 1'b0;
        pin_in = straps;
        repeat (3) @(negedge clk);
        por_n = 1'b1;
    endtask

    task automatic t_reset();
        por_n = 1'b0;
        pin_in = 5'h1f;
        clk_src = 5'h1f;
        repeat (4) @(negedge clk);
        check("R1 oe", {3'b0, pin_oe}, 8'h00);
        check("R1 out", {3'b0, pin_out}, 8'h00);
        check("R1 valid", {7'b0, strap_valid}, 8'h00);
        check("R1 code", {3'b0, mode_sel, freq_sel}, 8'h00);
    endtask

    task automatic t_window(input logic [4:0] straps);
        power_up(straps);
        edges(WIN);
        check("R2 valid at window end", {7'b0, strap_valid}, 8'h00);
        check("R2 oe at window end", {3'b0, pin_oe}, 8'h00);
        edges(1);
        check("R3 valid after capture", {7'b0, strap_valid}, 8'h01);
        check("R6 freq_sel", {4'b0, freq_sel}, {4'b0, straps[3:0]});
        check("R6 mode_sel", {7'b0, mode_sel}, {7'b0, straps[4]});
        check("R4 oe one edge late", {3'b0, pin_oe}, 8'h00);
        edges(1);
        check("R4 oe on", {3'b0, pin_oe}, 8'h1f);
    endtask

    // Change straps just before or just after the edge the snapshot reflects.
    task automatic t_boundary(input logic [4:0] a, input logic [4:0] b, input bit late);
        power_up(a);
        edges(late ? WIN + 1 - SYNC : WIN - SYNC);
        pin_in = b;
        edges(late ? SYNC : SYNC + 1);
        check(late ? "R3 late change keeps old" : "R3 early change takes new",
              {3'b0, mode_sel, freq_sel}, {3'b0, late ? a : b});
        check("R3 valid", {7'b0, strap_valid}, 8'h01);
    endtask

    task automatic t_sticky(input logic [4:0] straps);
        t_window(straps);
        pin_in = ~straps;
        edges(1);
        check("R5 code after pin flip", {3'b0, mode_sel, freq_sel}, {3'b0, straps});
        pin_in = 5'h0a;
        edges(40);
        check("R5 code after long run", {3'b0, mode_sel, freq_sel}, {3'b0, straps});
        check("R4 oe stays", {3'b0, pin_oe}, 8'h1f);
    endtask

    task automatic t_pad();
        power_up(5'h03);
        clk_src = 5'h15;
        edges(WIN);
        check("R7 quiet in window", {3'b0, pin_out}, 8'h00);
        edges(2);
        check("R7 passes clk_src", {3'b0, pin_out}, 8'h15);
        clk_src = 5'h0a;
        #1;
        check("R7 follows clk_src", {3'b0, pin_out}, 8'h0a);
    endtask

    task automatic t_repower();
        t_window(5'h09);
        por_n = 1'b0;
        #3;
        check("R8 cleared valid", {7'b0, strap_valid}, 8'h00);
        check("R8 cleared oe", {3'b0, pin_oe}, 8'h00);
        power_up(5'h16);
        edges(WIN);
        check("R8 full new window", {7'b0, strap_valid}, 8'h00);
        edges(1);
        check("R8 new code", {3'b0, mode_sel, freq_sel}, 8'h16);
    endtask

    initial begin
        t_reset();
        t_window(5'h16);
        t_window(5'h00);
        t_window(5'h1f);
        t_boundary(5'h05, 5'h1a, 1'b0);
        t_boundary(5'h05, 5'h1a, 1'b1);
        t_sticky(5'h13);
        t_pad();
        t_repower();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(200000 * 8);
        total++;
        bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule